// File: doc/BRIEF.md
# Dual-Mode Integer Multiply-Accumulate Unit

The unit multiplies two 32-bit operands and adds the product to an accumulator. It does this in one cycle and has two modes. In long mode the full 32x32 product, signed or unsigned, is added to a 64-bit accumulator and the sum wraps to 64 bits. In dual mode each operand is split into two signed 16-bit halves. The two halfword products are summed with the low 32 bits of the accumulator, giving a 32-bit sum-of-products that is sign-extended to 64 bits.

An exchange control can swap the halves of the second operand before the dual multiply, so cross products such as `a_lo*b_hi + a_hi*b_lo` come from the same path. Every valid input yields a registered result one clock later, and a new operation may be issued every cycle. A sticky flag records any signed overflow of the dual-mode 32-bit sum.

Top module: `dual_mac_unit`

## Requirements
- R1: With `mode_i`=0 (long) and `signed_i`=1, `result_o` = `acc_i` + signed(`op_a_i`) * signed(`op_b_i`), modulo 2^64.
- R2: With `mode_i`=0 and `signed_i`=0, `result_o` = `acc_i` + unsigned(`op_a_i`) * unsigned(`op_b_i`), modulo 2^64.
- R3: With `mode_i`=1 (dual) and `exch_i`=0, the following hold, where the low half is bits 15:0 and the high half is bits 31:16, both signed:
  - `result_o[31:0]` = `acc_i[31:0]` + a_lo*b_lo + a_hi*b_hi, modulo 2^32.
  - `result_o[63:32]` copies bit 31.
  - `acc_i[63:32]` has no effect.
- R4: In dual mode, `exch_i`=1 swaps the halves of `op_b_i`, so the sum is `acc_i[31:0]` + a_lo*b_hi + a_hi*b_lo. In long mode `exch_i` has no effect.
- R5: In dual mode, `signed_i` has no effect; halfwords are always signed.
- R6: `valid_o` is 1 exactly one clock after a cycle with `valid_i`=1 and is 0 otherwise; the result of that operation is on `result_o` in the same cycle. Operations may be issued back to back.
- R7: When `valid_i` is 0, `result_o` keeps its previous value, whatever the other inputs do.
- R8: `ovf_o` becomes 1 one clock after a valid dual operation whose exact sum lies outside [-2^31, 2^31-1]. It then stays 1 until reset. Long-mode operations never set it.
- R9: While `rst_ni` is low, `valid_o`, `result_o` and `ovf_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation request |
| mode_i | input | 1 | 0 = long 32x32+64, 1 = dual 16x16 sum-of-products |
| signed_i | input | 1 | Long mode: 1 = signed operands, 0 = unsigned |
| exch_i | input | 1 | Dual mode: swap halves of `op_b_i` |
| op_a_i | input | 32 | First operand |
| op_b_i | input | 32 | Second operand |
| acc_i | input | 64 | Accumulator addend |
| valid_o | output | 1 | Result valid |
| result_o | output | 64 | Registered result |
| ovf_o | output | 1 | Sticky dual-mode signed overflow |

## Verification
Every result, the valid strobe and the overflow flag are due one rising edge after the request. The bench applies each operation at a falling edge and compares the outputs at the next falling edge, so back-to-back operations are checked against their own expected values. Idle cycles with scrambled inputs are checked one edge later for an unchanged result and a low `valid_o`. Expected values are built from 64-bit integer arithmetic in the bench, including the exact dual-mode sum that decides overflow.

// File: rtl/mac_pkg.sv
`timescale 1ns/1ps
package mac_pkg;
  typedef enum logic {
    MODE_LONG = 1'b0,
    MODE_DUAL = 1'b1
  } mac_mode_e;
endpackage

// File: rtl/mac_operand_route.sv
`timescale 1ns/1ps
module mac_operand_route #(
  parameter int OP_W = 32
) (
  input  logic [OP_W-1:0] b_i,
  input  logic            exch_i,
  output logic [OP_W-1:0] b_o
);
  localparam int HALF_W = OP_W / 2;

  always_comb begin
    if (exch_i) b_o = {b_i[HALF_W-1:0], b_i[OP_W-1:HALF_W]};
    else        b_o = b_i;
  end
endmodule

// File: rtl/mac_lane_mul.sv
`timescale 1ns/1ps
module mac_lane_mul #(
  parameter int HALF_W = 16
) (
  input  logic [HALF_W-1:0]   x_i,
  input  logic [HALF_W-1:0]   y_i,
  output logic [2*HALF_W-1:0] p_o
);
  localparam int PROD_W = 2 * HALF_W;

  logic [PROD_W-1:0] xs, ys;

  // sign-extend to product width; low PROD_W bits of the product are exact
  assign xs  = {{HALF_W{x_i[HALF_W-1]}}, x_i};
  assign ys  = {{HALF_W{y_i[HALF_W-1]}}, y_i};
  assign p_o = xs * ys;
endmodule

// File: rtl/mac_wide_mul.sv
`timescale 1ns/1ps
module mac_wide_mul #(
  parameter int OP_W = 32
) (
  input  logic [OP_W-1:0]   a_i,
  input  logic [OP_W-1:0]   b_i,
  input  logic              signed_i,
  input  logic [2*OP_W-1:0] acc_i,
  output logic [2*OP_W-1:0] sum_o
);
  localparam int ACC_W = 2 * OP_W;

  logic [ACC_W-1:0] ax, bx, prod;

  assign ax    = {{OP_W{signed_i & a_i[OP_W-1]}}, a_i};
  assign bx    = {{OP_W{signed_i & b_i[OP_W-1]}}, b_i};
  assign prod  = ax * bx;
  assign sum_o = prod + acc_i;
endmodule

// File: rtl/mac_dual_sum.sv
`timescale 1ns/1ps
module mac_dual_sum #(
  parameter int W = 32
) (
  input  logic [W-1:0] p0_i,
  input  logic [W-1:0] p1_i,
  input  logic [W-1:0] acc_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o
);
  localparam int GUARD = 2;
  localparam int SUM_W = W + GUARD;

  logic [SUM_W-1:0] e0, e1, ea, full;
  logic [GUARD:0]   top;

  assign e0    = {{GUARD{p0_i[W-1]}}, p0_i};
  assign e1    = {{GUARD{p1_i[W-1]}}, p1_i};
  assign ea    = {{GUARD{acc_i[W-1]}}, acc_i};
  assign full  = e0 + e1 + ea;
  assign sum_o = full[W-1:0];
  assign top   = full[SUM_W-1:W-1];
  // representable only when guard bits all match the sign bit
  assign ovf_o = ~((&top) | ~(|top));
endmodule

// File: rtl/dual_mac_unit.sv
`timescale 1ns/1ps
module dual_mac_unit
  import mac_pkg::*;
#(
  parameter int OP_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic                mode_i,
  input  logic                signed_i,
  input  logic                exch_i,
  input  logic [OP_W-1:0]     op_a_i,
  input  logic [OP_W-1:0]     op_b_i,
  input  logic [2*OP_W-1:0]   acc_i,
  output logic                valid_o,
  output logic [2*OP_W-1:0]   result_o,
  output logic                ovf_o
);
  localparam int HALF_W = OP_W / 2;
  localparam int ACC_W  = 2 * OP_W;
  localparam int PROD_W = 2 * HALF_W;
  localparam int LANES  = 2;

  mac_mode_e         mode;
  logic [OP_W-1:0]   b_rt;
  logic [PROD_W-1:0] lane_p [LANES];
  logic [OP_W-1:0]   dual_sum;
  logic              dual_ovf;
  logic [ACC_W-1:0]  long_sum;
  logic [ACC_W-1:0]  res_d;
  logic              valid_q;
  logic [ACC_W-1:0]  res_q;
  logic              ovf_q;

  assign mode = mac_mode_e'(mode_i);

  mac_operand_route #(.OP_W(OP_W)) u_route (
    .b_i    (op_b_i),
    .exch_i (exch_i),
    .b_o    (b_rt)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    mac_lane_mul #(.HALF_W(HALF_W)) u_mul (
      .x_i (op_a_i[g*HALF_W +: HALF_W]),
      .y_i (b_rt[g*HALF_W +: HALF_W]),
      .p_o (lane_p[g])
    );
  end

  mac_dual_sum #(.W(OP_W)) u_dsum (
    .p0_i  (lane_p[0]),
    .p1_i  (lane_p[1]),
    .acc_i (acc_i[OP_W-1:0]),
    .sum_o (dual_sum),
    .ovf_o (dual_ovf)
  );

  mac_wide_mul #(.OP_W(OP_W)) u_wide (
    .a_i      (op_a_i),
    .b_i      (op_b_i),
    .signed_i (signed_i),
    .acc_i    (acc_i),
    .sum_o    (long_sum)
  );

  always_comb begin
    if (mode == MODE_DUAL) res_d = {{OP_W{dual_sum[OP_W-1]}}, dual_sum};
    else                   res_d = long_sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      ovf_q   <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) res_q <= res_d;
      if (valid_i && mode == MODE_DUAL && dual_ovf) ovf_q <= 1'b1;
    end
  end

  assign valid_o  = valid_q;
  assign result_o = res_q;
  assign ovf_o    = ovf_q;

  AST_VALID_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R6
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o)); // R7
  AST_DUAL_SEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i) |=> (result_o[ACC_W-1:OP_W] == {OP_W{result_o[OP_W-1]}})); // R3
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o); // R8
  AST_LONG_NO_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !mode_i && !ovf_o) |=> !ovf_o); // R8
endmodule

// File: tb/sim_dual_mac_unit.sv
`timescale 1ns/1ps
module sim_dual_mac_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        mode_i = 1'b0;
  logic        signed_i = 1'b0;
  logic        exch_i = 1'b0;
  logic [31:0] op_a_i = '0;
  logic [31:0] op_b_i = '0;
  logic [63:0] acc_i = '0;
  logic        valid_o;
  logic [63:0] result_o;
  logic        ovf_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [63:0] last_res = '0;
  logic        exp_ovf = 1'b0;

  always #2 clk_i = ~clk_i;

  dual_mac_unit u0 (
    .clk_i, .rst_ni, .valid_i, .mode_i, .signed_i, .exch_i,
    .op_a_i, .op_b_i, .acc_i, .valid_o, .result_o, .ovf_o
  );

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_long(bit sg, logic [31:0] a, logic [31:0] b,
                                           logic [63:0] acc);
    logic [63:0] ax, bx;
    ax = sg ? {{32{a[31]}}, a} : {32'b0, a};
    bx = sg ? {{32{b[31]}}, b} : {32'b0, b};
    return acc + ax * bx;
  endfunction

  task automatic ref_dual(bit ex, logic [31:0] a, logic [31:0] b, logic [63:0] acc,
                          output logic [63:0] res, output bit ovf);
    logic [31:0] bb;
    longint p0, p1, s;
    bb  = ex ? {b[15:0], b[31:16]} : b;
    p0  = longint'($signed(a[15:0])) * longint'($signed(bb[15:0]));
    p1  = longint'($signed(a[31:16])) * longint'($signed(bb[31:16]));
    s   = p0 + p1 + longint'($signed(acc[31:0]));
    ovf = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    res = {{32{s[31]}}, s[31:0]};
  endtask

  // drive at a falling edge, compare at the next falling edge
  task automatic do_op(bit md, bit sg, bit ex, logic [31:0] a, logic [31:0] b,
                       logic [63:0] acc, string req);
    logic [63:0] e;
    bit o;
    valid_i = 1'b1; mode_i = md; signed_i = sg; exch_i = ex;
    op_a_i = a; op_b_i = b; acc_i = acc;
    if (md) begin
      ref_dual(ex, a, b, acc, e, o);
      exp_ovf = exp_ovf | o;
    end else begin
      e = ref_long(sg, a, b, acc);
    end
    @(negedge clk_i);
    check({req, " result"}, result_o, e);
    check("R6 valid_o", {63'b0, valid_o}, 64'd1);
    check("R8 ovf_o", {63'b0, ovf_o}, {63'b0, exp_ovf});
    last_res = e;
  endtask

  task automatic do_idle();
    valid_i = 1'b0; mode_i = ~mode_i; signed_i = ~signed_i; exch_i = ~exch_i;
    op_a_i = ~op_a_i; op_b_i = op_b_i ^ 32'h5A5A_A5A5; acc_i = ~acc_i;
    @(negedge clk_i);
    check("R7 hold", result_o, last_res);
    check("R6 idle valid_o", {63'b0, valid_o}, 64'd0);
  endtask

  task automatic do_reset();
    valid_i = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R9 valid_o", {63'b0, valid_o}, 64'd0);
    check("R9 result_o", result_o, 64'd0);
    check("R9 ovf_o", {63'b0, ovf_o}, 64'd0);
    rst_ni = 1'b1;
    exp_ovf = 1'b0;
    last_res = '0;
    @(negedge clk_i);
  endtask

  logic [15:0] hw [8] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF,
                          16'h8000, 16'h1234, 16'hC3A5, 16'h0100};
  logic [31:0] wv [8] = '{32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                          32'h8000_0000, 32'h1234_5678, 32'hDEAD_BEEF, 32'h0001_0000};
  logic [63:0] av [4] = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF,
                          64'h8000_0000_0000_0000, 64'h0123_4567_89AB_CDEF};

  initial begin
    @(negedge clk_i);
    do_reset();

    // R8: directed overflow cases
    do_op(1'b1, 1'b0, 1'b0, 32'h7FFF_7FFF, 32'h0001_0001, 64'h0, "R3 small");
    do_op(1'b0, 1'b1, 1'b0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, "R1 big");
    check("R8 long leaves ovf low", {63'b0, ovf_o}, 64'd0);
    do_op(1'b1, 1'b0, 1'b0, 32'h8000_8000, 32'h8000_8000, 64'h0, "R3 wrap");
    check("R8 overflow set", {63'b0, ovf_o}, 64'd1);
    do_op(1'b1, 1'b0, 1'b0, 32'h0002_0003, 32'h0004_0005, 64'h0, "R3 after ovf");
    check("R8 sticky", {63'b0, ovf_o}, 64'd1);
    do_idle();
    do_reset();
    do_op(1'b1, 1'b1, 1'b0, 32'h0000_8000, 32'h0000_8000, 64'h0000_0000_7FFF_FFFF, "R3 edge");
    check("R8 positive overflow", {63'b0, ovf_o}, 64'd1);
    do_reset();
    do_op(1'b1, 1'b0, 1'b1, 32'h7FFF_0001, 32'h8000_0001, 64'h0000_0000_8000_0000, "R4 neg ovf");
    check("R8 negative overflow", {63'b0, ovf_o}, 64'd1);
    do_reset();

    // long mode sweep: R1 signed, R2 unsigned, R4 exch ignored
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int k = 0; k < 4; k++)
          for (int m = 0; m < 4; m++) begin
            do_op(1'b0, m[0], m[1], wv[i], wv[j], av[k], m[0] ? "R1 long signed" : "R2 long unsigned");
            if (((i + j + k + m) % 16) == 0) do_idle();
          end

    // dual mode sweep: R3 straight, R4 exchange, R5 signed_i ignored
    for (int al = 0; al < 8; al++)
      for (int ah = 0; ah < 8; ah++)
        for (int bl = 0; bl < 8; bl++)
          for (int bh = 0; bh < 8; bh++)
            for (int x = 0; x < 2; x++) begin
              int n;
              n = al + ah * 3 + bl * 5 + bh * 7 + x;
              do_op(1'b1, n[1], x[0], {hw[ah], hw[al]}, {hw[bh], hw[bl]},
                    {wv[n % 8], av[n % 4][31:0]},
                    x[0] ? "R4 dual exch" : (n[1] ? "R5 dual sgn" : "R3 dual"));
              if ((n % 64) == 0) do_idle();
            end

    do_idle();
    do_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule